// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of several fans at once. Each fan's tach line is brought into the clock domain and its rising edges are detected. The block then counts strobes of a slow timebase (nominally 90 kHz, supplied as a one-cycle `tick` strobe) over a programmable number of consecutive tach periods. A slow fan therefore gives a large count. A fan that stops, or that was never fitted, drives its count to the all-ones value.

Software-side logic reads each count as two bytes. Reading the low byte locks that fan's result until the high byte of the same fan has been read, so the two halves always come from one measurement. Each fan also has a minimum-speed limit, expressed as a maximum count, and an alarm flag that rises when a valid count exceeds that limit.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, every byte read returns 0x00 and every alarm is low until that fan completes its first measurement. The period setting resets to 2 and every limit resets to all ones.
- R2: A fan's result is the number of `tick` strobes seen after the cycle of a synchronized rising tach edge, up to and including the cycle of the rising edge that closes N whole tach periods. For periodic inputs this equals N*P/D, where P is the tach period and D is the tick spacing in clocks.
- R3: N is set through `ppm_we`/`ppm_val` and applies to all fans. A value of 0 acts as 1.
- R4: Measurements repeat without a gap. Each completed measurement replaces the previous result of that fan unless the fan is locked.
- R5: If the running count reaches all ones (2^CNT_W-1) before N periods complete, the result is all ones. This covers both a fan with no tach edges and a fan that is too slow.
- R6: With `rd_en` high, `rd_data` on the next cycle is bits 7:0 of the selected fan's result when `rd_hi`=0, and bits 15:8 of the result zero-extended to 16 bits when `rd_hi`=1. `rd_data` holds its value when `rd_en` is low.
- R7: A low-byte read of a fan locks its result. While locked, completed measurements are discarded, including one that completes in the same cycle as the low-byte read. A high-byte read of that fan releases the lock.
- R8: `alarm[i]` is high exactly when fan i has a valid result greater than its limit, written through `lim_we`/`lim_sel`/`lim_val`. A limit of all ones never alarms.
- R9: Locking one fan does not stop other fans from updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe |
| tach_in | input | NUM_FANS | Asynchronous tach inputs, one per fan |
| ppm_we | input | 1 | Write strobe for the period setting |
| ppm_val | input | PPR_W | Tach periods per measurement (N) |
| lim_we | input | 1 | Write strobe for a fan limit |
| lim_sel | input | SEL_W | Fan selected by the limit write |
| lim_val | input | CNT_W | New limit value (largest count that does not alarm) |
| rd_en | input | 1 | Byte read strobe |
| rd_sel | input | SEL_W | Fan selected for the read |
| rd_hi | input | 1 | 0 selects the low byte, 1 the high byte |
| rd_data | output | 8 | Registered read data |
| alarm | output | NUM_FANS | Per-fan slow-fan alarm |

## Verification
The sensitive overlap is a measurement completing in the same clock cycle as a low-byte read, or while the lock is held between the two reads. To provoke it, one fan's tach period alternates between two lengths with N=1, so that consecutive results differ in both bytes. Byte-pair reads are then swept across many offsets and lock lengths. Every reassembled word must equal one of the two legitimate counts, and any mixed pair is a failure. Both counts must also appear during the sweep.

// File: rtl/fan_tach_pkg.sv
// Shared helpers for the fan tachometer monitor.
// Assumes counts are at most 16 bits wide and are zero-extended before byte selection.
package fan_tach_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // Picks the upper or lower byte of a 16-bit word.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] word,
                                                    input logic upper);
        return upper ? word[15:8] : word[7:0];
    endfunction
endpackage

// File: rtl/tach_edge_detect.sv
// Two-flop synchronizer plus rising-edge detector for a vector of tach lines.
// Assumes the inputs are asynchronous and slow compared with clk.
// rise[i] is a one-cycle pulse, three cycles after the pin edge.
module tach_edge_detect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q, sync_q, prev_q;

    // Resynchronize the pins and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/tach_period_counter.sv
// Counts timebase strobes over a programmable number of tach periods for one fan.
// Assumes rise is a synchronized single-cycle edge pulse.
// The first edge after a start-up or a stall only aligns the count; later edges close periods.
// The count saturates: reaching all ones reports all ones and restarts alignment.
module tach_period_counter #(
    parameter int CNT_W = 16,
    parameter int PPR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    input  logic [PPR_W-1:0] periods,
    output logic             done,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             aligned_q;
    logic [PPR_W-1:0] edge_cnt_q;
    logic [CNT_W-1:0] tick_cnt_q;
    logic [PPR_W-1:0] target;
    logic [PPR_W-1:0] edge_nx;
    logic [CNT_W-1:0] tick_nx;

    // Effective period count (0 behaves as 1) and next-state counters.
    always_comb begin
        target  = (periods == '0) ? PPR_W'(1) : periods;
        edge_nx = edge_cnt_q + PPR_W'(1);
        tick_nx = tick ? tick_cnt_q + CNT_W'(1) : tick_cnt_q;
    end

    // Measurement sequencing: align, accumulate, complete or saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned_q  <= 1'b0;
            edge_cnt_q <= '0;
            tick_cnt_q <= '0;
            done       <= 1'b0;
            value      <= '0;
        end else begin
            done <= 1'b0;
            if (tick_cnt_q == CNT_MAX) begin
                done       <= 1'b1;
                value      <= CNT_MAX;
                tick_cnt_q <= '0;
                edge_cnt_q <= '0;
                aligned_q  <= 1'b0;
            end else if (rise && !aligned_q) begin
                aligned_q  <= 1'b1;
                tick_cnt_q <= '0;
                edge_cnt_q <= '0;
            end else if (rise && (edge_nx >= target)) begin
                done       <= 1'b1;
                value      <= tick_nx;
                tick_cnt_q <= '0;
                edge_cnt_q <= '0;
            end else if (rise) begin
                edge_cnt_q <= edge_nx;
                tick_cnt_q <= tick_nx;
            end else begin
                tick_cnt_q <= tick_nx;
            end
        end
    end
endmodule

// File: rtl/fan_tach_monitor.sv
// Multi-fan tachometer monitor: synchronizes tach lines, measures periods,
// and holds per-fan results with a low-then-high byte read lock and a slow-fan alarm.
// Assumes CNT_W is between 9 and 16 and NUM_FANS is at least 2.
module fan_tach_monitor #(
    parameter int NUM_FANS = 4,
    parameter int CNT_W    = 16,
    parameter int PPR_W    = 3,
    localparam int SEL_W   = $clog2(NUM_FANS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_FANS-1:0] tach_in,
    input  logic                ppm_we,
    input  logic [PPR_W-1:0]    ppm_val,
    input  logic                lim_we,
    input  logic [SEL_W-1:0]    lim_sel,
    input  logic [CNT_W-1:0]    lim_val,
    input  logic                rd_en,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic                rd_hi,
    output logic [7:0]          rd_data,
    output logic [NUM_FANS-1:0] alarm
);
    import fan_tach_pkg::*;

    localparam logic [PPR_W-1:0] DEF_PERIODS = PPR_W'(2);

    logic [PPR_W-1:0]                periods_q;
    logic [NUM_FANS-1:0]             rise;
    logic [NUM_FANS-1:0]             done_w;
    logic [NUM_FANS-1:0][CNT_W-1:0]  meas_w;
    logic [NUM_FANS-1:0][CNT_W-1:0]  result_w;
    logic [NUM_FANS-1:0][CNT_W-1:0]  limit_w;
    logic [NUM_FANS-1:0]             valid_w;
    logic [NUM_FANS-1:0]             frozen_w;
    logic [WORD_W-1:0]               rd_word;

    // Shared setting for the number of tach periods per measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)      periods_q <= DEF_PERIODS;
        else if (ppm_we) periods_q <= ppm_val;
    end

    tach_edge_detect #(.WIDTH(NUM_FANS)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (tach_in),
        .rise  (rise)
    );

    for (genvar i = 0; i < NUM_FANS; i++) begin : g_fan
        logic             lo_hit, hi_hit;
        logic [CNT_W-1:0] res_q, lim_q;
        logic             valid_q, frozen_q;

        tach_period_counter #(.CNT_W(CNT_W), .PPR_W(PPR_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .rise    (rise[i]),
            .periods (periods_q),
            .done    (done_w[i]),
            .value   (meas_w[i])
        );

        assign lo_hit = rd_en && !rd_hi && (rd_sel == SEL_W'(i));
        assign hi_hit = rd_en &&  rd_hi && (rd_sel == SEL_W'(i));

        // Result capture, blocked while locked or while the low byte is taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q    <= '0;
                valid_q  <= 1'b0;
                frozen_q <= 1'b0;
            end else begin
                if (done_w[i] && !frozen_q && !lo_hit) begin
                    res_q   <= meas_w[i];
                    valid_q <= 1'b1;
                end
                if (lo_hit)      frozen_q <= 1'b1;
                else if (hi_hit) frozen_q <= 1'b0;
            end
        end

        // Per-fan slow-fan limit.
        always_ff @(posedge clk) begin
            if (!rst_n)                               lim_q <= '1;
            else if (lim_we && lim_sel == SEL_W'(i))  lim_q <= lim_val;
        end

        assign result_w[i] = res_q;
        assign limit_w[i]  = lim_q;
        assign valid_w[i]  = valid_q;
        assign frozen_w[i] = frozen_q;
        assign alarm[i]    = valid_q && (res_q > lim_q);
    end

    // Selected result widened to a 16-bit word for byte selection.
    always_comb begin
        rd_word = '0;
        if (int'(rd_sel) < NUM_FANS) rd_word = WORD_W'(result_w[rd_sel]);
    end

    // Registered byte read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= pick_byte(rd_word, rd_hi);
    end
endmodule

// File: rtl/fan_tach_monitor_chk.sv
// Property checker for fan_tach_monitor, attached by bind.
// Observes the per-fan result, limit, valid and lock state next to the read port.
module fan_tach_monitor_chk #(
    parameter int NUM_FANS = 4,
    parameter int CNT_W    = 16,
    parameter int SEL_W    = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rd_en,
    input logic [SEL_W-1:0]              rd_sel,
    input logic                          rd_hi,
    input logic [7:0]                    rd_data,
    input logic [NUM_FANS-1:0]           alarm,
    input logic [NUM_FANS-1:0][CNT_W-1:0] result_w,
    input logic [NUM_FANS-1:0][CNT_W-1:0] limit_w,
    input logic [NUM_FANS-1:0]           valid_w,
    input logic [NUM_FANS-1:0]           frozen_w
);
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    for (genvar i = 0; i < NUM_FANS; i++) begin : g_fan
        // R7
        frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            frozen_w[i] |=> $stable(result_w[i]));
        // R7
        lo_read_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !rd_hi && rd_sel == SEL_W'(i)) |=> frozen_w[i]);
        // R1
        invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_w[i] |-> (result_w[i] == '0));
        // R4
        valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_w[i] |=> valid_w[i]);
        // R8
        alarm_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            alarm[i] |-> valid_w[i]);
        // R8
        limit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (limit_w[i] == '1) |-> !alarm[i]);
    end
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(
    .NUM_FANS (NUM_FANS),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W)
) u_chk (.*);

// File: tb/fan_tach_monitor_bench.sv
module fan_tach_monitor_bench;
    localparam int NF   = 4;
    localparam int CW   = 10;
    localparam int PW   = 3;
    localparam int SW   = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [NF-1:0] tach_in = '0;
    logic          ppm_we = 1'b0;
    logic [PW-1:0] ppm_val = '0;
    logic          lim_we = 1'b0;
    logic [SW-1:0] lim_sel = '0;
    logic [CW-1:0] lim_val = '0;
    logic          rd_en = 1'b0;
    logic [SW-1:0] rd_sel = '0;
    logic          rd_hi = 1'b0;
    logic [7:0]    rd_data;
    logic [NF-1:0] alarm;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int per_a [NF];
    int per_b [NF];
    int cur_per [NF];
    int phase [NF];

    always #5 clk = ~clk;

    fan_tach_monitor #(.NUM_FANS(NF), .CNT_W(CW), .PPR_W(PW)) u_fan_tach_monitor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tach_in(tach_in),
        .ppm_we(ppm_we), .ppm_val(ppm_val), .lim_we(lim_we), .lim_sel(lim_sel),
        .lim_val(lim_val), .rd_en(rd_en), .rd_sel(rd_sel), .rd_hi(rd_hi),
        .rd_data(rd_data), .alarm(alarm)
    );

    // Stimulus generator: tick strobe and per-fan tach waveforms, driven at negedge.
    initial begin
        for (int i = 0; i < NF; i++) begin
            per_a[i] = 0; per_b[i] = 0; cur_per[i] = 0; phase[i] = 0;
        end
        forever begin
            @(negedge clk);
            tick = (tick_ph == 0);
            tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
            for (int i = 0; i < NF; i++) begin
                if (cur_per[i] == 0) begin
                    tach_in[i] = 1'b0;
                    phase[i] = 0;
                end else begin
                    tach_in[i] = (phase[i] < cur_per[i] / 2);
                    phase[i] = phase[i] + 1;
                    if (phase[i] >= cur_per[i]) begin
                        phase[i] = 0;
                        if (per_b[i] != 0)
                            cur_per[i] = (cur_per[i] == per_a[i]) ? per_b[i] : per_a[i];
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_per(input int f, input int a, input int b);
        per_a[f] = a; per_b[f] = b; cur_per[f] = a;
    endtask

    task automatic set_ppm(input int n);
        @(negedge clk); ppm_we = 1'b1; ppm_val = PW'(n);
        @(negedge clk); ppm_we = 1'b0;
    endtask

    task automatic set_lim(input int f, input int v);
        @(negedge clk); lim_we = 1'b1; lim_sel = SW'(f); lim_val = CW'(v);
        @(negedge clk); lim_we = 1'b0;
    endtask

    task automatic rd_byte(input int f, input bit hi, output int d);
        @(negedge clk); rd_en = 1'b1; rd_sel = SW'(f); rd_hi = hi;
        @(negedge clk); rd_en = 1'b0; d = int'(rd_data);
    endtask

    task automatic rd_word(input int f, output int v);
        int lo, hi;
        rd_byte(f, 1'b0, lo);
        rd_byte(f, 1'b1, hi);
        v = (hi << 8) | lo;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, b, n200, n312;
        int pers [NF];
        pers[0] = 48; pers[1] = 60; pers[2] = 96; pers[3] = 150;

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state of read bytes and alarms; limit 0 still no alarm before valid
        for (int f = 0; f < NF; f++) begin
            rd_byte(f, 1'b0, b); check("R1 reset low byte", b, 0);
            rd_byte(f, 1'b1, b); check("R1 reset high byte", b, 0);
        end
        check("R1 reset alarms", int'(alarm), 0);
        set_lim(0, 0);
        check("R1 no alarm before first measurement", int'(alarm[0]), 0);
        set_lim(0, CMAX);

        // R1: default of 2 periods per measurement
        set_per(0, 48, 0);
        wait_cyc(3 * 96 + 40);
        rd_word(0, v); check("R1 default two periods", v, 96);

        // R2 R3: sweep tick spacing and period count over four fans
        for (int d = 1; d <= 3; d++) begin
            for (int n = 1; n <= 4; n++) begin
                tick_div = d;
                set_ppm(n);
                for (int f = 0; f < NF; f++) set_per(f, pers[f], 0);
                wait_cyc(3 * n * 150 + 60);
                for (int f = 0; f < NF; f++) begin
                    rd_word(f, v);
                    check($sformatf("R2 R3 fan%0d d=%0d n=%0d", f, d, n), v, n * pers[f] / d);
                end
            end
        end

        // R3: a setting of 0 behaves as 1
        tick_div = 1;
        set_ppm(0);
        wait_cyc(3 * 150 + 60);
        for (int f = 0; f < NF; f++) begin
            rd_word(f, v); check("R3 zero acts as one", v, pers[f]);
        end

        // R4: a new period replaces the old result without other action
        set_per(2, 120, 0);
        wait_cyc(3 * 150 + 60);
        rd_word(2, v); check("R4 continuous update", v, 120);

        // R6 R7 R9: lock fan 0 with a low read, change periods, verify hold and independence
        set_ppm(2);
        set_per(0, 200, 0);
        set_per(1, 100, 0);
        wait_cyc(3 * 400 + 60);
        rd_byte(0, 1'b0, b); check("R6 low byte of 400", b, 400 & 8'hFF);
        set_per(0, 300, 0);
        set_per(1, 150, 0);
        wait_cyc(2000);
        rd_word(1, v); check("R9 other fan updates while fan0 locked", v, 300);
        rd_byte(0, 1'b1, b); check("R7 locked high byte", b, 400 >> 8);
        wait_cyc(3 * 600 + 60);
        rd_word(0, v); check("R7 released then updated", v, 600);

        // R8: alarm threshold around a count of 96
        set_per(0, 48, 0);
        wait_cyc(3 * 96 + 60);
        set_lim(0, 95); check("R8 count above limit", int'(alarm[0]), 1);
        set_lim(0, 96); check("R8 count equal to limit", int'(alarm[0]), 0);
        set_lim(0, CMAX); check("R8 limit all ones", int'(alarm[0]), 0);

        // R5: absent fan and too-slow fan both saturate
        set_per(3, 0, 0);
        set_per(2, 600, 0);
        wait_cyc(3000);
        rd_word(3, v); check("R5 absent fan", v, CMAX);
        rd_word(2, v); check("R5 too slow fan", v, CMAX);
        check("R8 stalled fan with limit all ones", int'(alarm[3]), 0);
        set_lim(3, CMAX - 1); check("R8 stalled fan alarm", int'(alarm[3]), 1);

        // R7: coherence sweep with alternating periods and N=1
        set_ppm(1);
        set_per(1, 200, 312);
        wait_cyc(1200);
        n200 = 0; n312 = 0;
        for (int it = 0; it < 150; it++) begin
            int lo, hi;
            rd_byte(1, 1'b0, lo);
            wait_cyc(it % 37);
            rd_byte(1, 1'b1, hi);
            v = (hi << 8) | lo;
            if (v == 200) n200++;
            else if (v == 312) n312++;
            else check("R7 coherent byte pair", v, 200);
            wait_cyc(it % 11);
        end
        check("R7 sweep saw short count", int'(n200 > 0), 1);
        check("R7 sweep saw long count", int'(n312 > 0), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule